// File: doc/BRIEF.md
# 10BASE-T Nibble Transmitter with Jabber Lockout

This block is the transmit side of a 10 Mb/s twisted-pair port. It accepts 4-bit parallel NRZ nibbles from a media-independent-interface style source. Each nibble is qualified by a transmit enable. The block converts each nibble to a serial bit stream and Manchester-codes that stream onto a single line bit. A local half-bit timebase paces the whole block. The block pulses `nib_take` in the clock cycle in which it samples `tx_en` and `txd`, so the source presents its next nibble in that cycle.

When no data is being sent, the block emits periodic link-integrity pulses. Each pulse is one half-bit wide. A flag reports the low-power idle condition, in which neither data nor a pulse is on the line.

A length guard counts how long `tx_en` has been held. If that count reaches its limit, the block enters a jabber lockout. In lockout it silences the line completely and keeps the `jabber` flag high, so management logic can read it. The lockout ends only after `tx_en` has been low for an unbroken holdoff period. All three intervals are parameters in clock cycles. Their defaults suit a 50 MHz clock: 16 ms between link pulses, a 20 ms transmit limit and a 500 ms holdoff.

Top module: `tp10_nibble_tx`

## Requirements
- R1: After reset, `line_out`, `line_active` and `jabber` are 0 and `low_power` is 1.
- R2: A nibble on `txd` is captured when `tx_en` is 1 in a cycle where `nib_take` is 1. `nib_take` recurs every 8*HALF_TICKS cycles. In the following 8*HALF_TICKS cycles the nibble is sent least significant bit first, `txd[0]` then `txd[3]`, and each bit takes two half-bits of HALF_TICKS cycles.
- R3: Manchester coding: a 1 bit is sent as low in the first half-bit and high in the second; a 0 bit is sent as high then low.
- R4: When `tx_en` is 0 in a `nib_take` cycle, no data is sent in the next slot, and `line_active` is 0 once the last data slot has ended.
- R5: While no data is being sent and no lockout is active, the line carries a high pulse HALF_TICKS cycles wide. Successive pulses start exactly LINK_TICKS cycles apart. No link pulse appears while data is being sent.
- R6: `low_power` is 1 exactly when neither data nor a link pulse is being driven; `line_active` is always its complement.
- R7: If `tx_en` is 1 for JAB_TICKS consecutive clock edges, `jabber` is 1 after the last of those edges and data output stops in the same cycle.
- R8: While `jabber` is 1, `tx_en` and `txd` have no effect: `line_out` and `line_active` stay 0 and no link pulses are sent.
- R9: `jabber` returns to 0 only after `tx_en` has been 0 on UNJAB_TICKS consecutive clock edges. Any edge with `tx_en` at 1 restarts that count.
- R10: A frame whose `tx_en` stays high for fewer than JAB_TICKS cycles never raises `jabber`, and all of its nibbles are sent.
- R11: After the lockout ends, nibbles are again accepted and sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable qualifying `txd` |
| txd | input | 4 | Transmit nibble, NRZ |
| nib_take | output | 1 | High in the cycle in which `tx_en` and `txd` are sampled |
| line_out | output | 1 | Manchester-coded line bit or link pulse |
| line_active | output | 1 | Data or a link pulse is being driven |
| low_power | output | 1 | Line idle with no pulse; transmitter may power down |
| jabber | output | 1 | Jabber lockout in effect |

## Verification
The hardest situation to reach is the lockout exit. It requires a stretch of `tx_en` high that is just long enough to trip the guard. This must be followed by an idle run that is interrupted once, so that the restarted holdoff count can be told apart from an uninterrupted one. The bench uses small parameter values for the limit and the holdoff. It counts clock edges from a known negedge, checks that `jabber` stays low until the exact trip edge, and then drives a low stretch with a one-cycle high glitch. It then confirms that the flag is still set one edge before the full holdoff has elapsed after the glitch, and clear on that edge. Nibble and link pulse checks reuse the bench's own timing model of the slot boundaries; they do not inspect the design's counters.

// File: rtl/tp10_nibble_tx.sv
`timescale 1ns/1ps
module tp10_nibble_tx #(
  parameter int HALF_TICKS  = 5,
  parameter int LINK_TICKS  = 800000,
  parameter int JAB_TICKS   = 1000000,
  parameter int UNJAB_TICKS = 25000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       nib_take,
  output logic       line_out,
  output logic       line_active,
  output logic       low_power,
  output logic       jabber
);
  localparam int HW = $clog2(HALF_TICKS + 1);
  localparam int LW = $clog2(LINK_TICKS + 1);
  localparam int JW = $clog2(JAB_TICKS + 1);
  localparam int UW = $clog2(UNJAB_TICKS + 1);

  logic [HW-1:0] hb_cnt, pw_cnt;
  logic [2:0]    ph;
  logic [3:0]    shreg;
  logic          sending, pulse_on, jab_q;
  logic [LW-1:0] lp_cnt;
  logic [JW-1:0] jab_cnt;
  logic [UW-1:0] uj_cnt;

  wire hb_stb    = hb_cnt == HW'(HALF_TICKS - 1);
  wire jab_trip  = !jab_q && tx_en && jab_cnt == JW'(JAB_TICKS - 1);
  wire jab_clear = jab_q && !tx_en && uj_cnt == UW'(UNJAB_TICKS - 1);
  wire cur_bit   = shreg[ph[2:1]];

  assign nib_take    = hb_stb && ph == 3'd7;
  assign line_out    = sending ? (ph[0] ? cur_bit : ~cur_bit) : pulse_on;
  assign line_active = sending | pulse_on;
  assign low_power   = ~line_active;
  assign jabber      = jab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_cnt <= '0;
      ph     <= '0;
    end else begin
      hb_cnt <= hb_stb ? '0 : hb_cnt + 1'b1;
      if (hb_stb) ph <= ph + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      shreg   <= '0;
    end else if (jab_trip || jab_q) begin
      sending <= 1'b0;
    end else if (nib_take) begin
      sending <= tx_en;
      shreg   <= txd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab_q   <= 1'b0;
      jab_cnt <= '0;
      uj_cnt  <= '0;
    end else begin
      if (jab_trip)       jab_q <= 1'b1;
      else if (jab_clear) jab_q <= 1'b0;
      if (jab_q || !tx_en)                   jab_cnt <= '0;
      else if (jab_cnt != JW'(JAB_TICKS - 1)) jab_cnt <= jab_cnt + 1'b1;
      if (!jab_q || tx_en || jab_clear) uj_cnt <= '0;
      else                              uj_cnt <= uj_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_cnt   <= '0;
      pw_cnt   <= '0;
      pulse_on <= 1'b0;
    end else if (sending || jab_q) begin
      lp_cnt   <= '0;
      pw_cnt   <= '0;
      pulse_on <= 1'b0;
    end else begin
      if (pulse_on) begin
        if (pw_cnt == HW'(HALF_TICKS - 1)) pulse_on <= 1'b0;
        else                               pw_cnt   <= pw_cnt + 1'b1;
      end
      if (lp_cnt == LW'(LINK_TICKS - 1)) begin
        lp_cnt   <= '0;
        pw_cnt   <= '0;
        pulse_on <= 1'b1;
      end else begin
        lp_cnt <= lp_cnt + 1'b1;
      end
    end
  end

  AST_MANCH_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
    sending && $past(sending) && ph[0] && !$past(ph[0]) |-> line_out != $past(line_out)); // R3
  AST_NO_PULSE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> !pulse_on); // R5
  AST_JAB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_q) |-> $past(tx_en)); // R7
  AST_JAB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    jab_q |-> !line_active && !line_out); // R8
  AST_JAB_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_q) |-> $past(!tx_en)); // R9
endmodule

// File: tb/tp10_nibble_tx_bench.sv
`timescale 1ns/1ps
module tp10_nibble_tx_bench;
  localparam int HB = 2, LNK = 400, JAB = 200, UJ = 300;
  localparam int SLOT = 8 * HB;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
  logic [3:0] txd = '0;
  logic nib_take, line_out, line_active, low_power, jabber;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tp10_nibble_tx #(.HALF_TICKS(HB), .LINK_TICKS(LNK), .JAB_TICKS(JAB), .UNJAB_TICKS(UJ)) u_tp10_nibble_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .nib_take(nib_take),
    .line_out(line_out), .line_active(line_active), .low_power(low_power), .jabber(jabber));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_frame(input logic [3:0] nibs [16], input int n, input string req);
    int bad = 0;
    do @(negedge clk); while (!nib_take);
    tx_en = 1'b1;
    txd = nibs[0];
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < SLOT; k++) begin
        logic b, e;
        @(negedge clk);
        b = nibs[i][(k / HB) / 2];
        e = ((k / HB) % 2) ? b : ~b;
        if (line_out !== e || line_active !== 1'b1 || low_power !== 1'b0) begin
          if (bad == 0) chk(1'b0, req, int'(line_out), int'(e));
          bad++;
        end
        if (k == SLOT - 1) begin
          chk(nib_take === 1'b1, "R2 slot boundary", int'(nib_take), 1);
          if (i + 1 < n) txd = nibs[i + 1];
          else tx_en = 1'b0;
        end
      end
    end
    chk(bad == 0, req, bad, 0);
    @(negedge clk);
    chk(line_active === 1'b0 && low_power === 1'b1, "R4 R6 idle after frame", int'(line_active), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(line_out === 1'b0 && line_active === 1'b0, "R1 line quiet in reset", int'(line_out), 0);
    chk(low_power === 1'b1, "R1 low_power in reset", int'(low_power), 1);
    chk(jabber === 1'b0, "R1 jabber in reset", int'(jabber), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_active === 1'b0 && jabber === 1'b0, "R1 state after release", int'(line_active), 0);
  endtask

  task automatic t_link(input string tag);
    int gap, w, guard;
    logic prev;
    guard = 0;
    prev = line_out;
    do begin @(negedge clk); guard++; if (line_out && !prev) break; prev = line_out; end while (guard < 3 * LNK);
    chk(guard < 3 * LNK, {tag, " R5 pulse seen"}, guard, LNK);
    w = 0;
    while (line_out === 1'b1) begin
      chk(line_active === 1'b1 && low_power === 1'b0, {tag, " R6 flags in pulse"}, int'(low_power), 0);
      w++;
      @(negedge clk);
    end
    chk(w == HB, {tag, " R5 pulse width"}, w, HB);
    chk(low_power === 1'b1, {tag, " R6 low_power between pulses"}, int'(low_power), 1);
    gap = w;
    prev = 1'b0;
    while (!(line_out === 1'b1 && prev === 1'b0) && gap < 3 * LNK) begin
      prev = line_out;
      @(negedge clk);
      gap++;
    end
    chk(gap == LNK, {tag, " R5 pulse period"}, gap, LNK);
  endtask

  task automatic t_data;
    logic [3:0] a [16];
    for (int i = 0; i < 16; i++) a[i] = 4'(i * 7 + 3);
    a[0] = 4'h0; a[1] = 4'hF; a[2] = 4'h5; a[3] = 4'hA;
    send_frame(a, 4, "R2 R3 edge patterns");
    send_frame(a, 12, "R10 long frame under limit");
    chk(jabber === 1'b0, "R10 no jabber on long frame", int'(jabber), 0);
    repeat (SLOT) @(negedge clk);
    chk(line_active === 1'b0 || line_out === 1'b1, "R4 no data with tx_en low", int'(line_active), 0);
  endtask

  task automatic t_jabber;
    int early, noisy;
    do @(negedge clk); while (line_active);
    tx_en = 1'b1;
    txd = 4'hF;
    early = 0;
    for (int i = 0; i < JAB - 1; i++) begin @(negedge clk); if (jabber) early++; end
    chk(early == 0, "R7 no trip before limit", early, 0);
    @(negedge clk);
    chk(jabber === 1'b1, "R7 trip at limit", int'(jabber), 1);
    chk(line_active === 1'b0, "R7 output stops at trip", int'(line_active), 0);
    noisy = 0;
    for (int i = 0; i < 3 * LNK; i++) begin
      txd = 4'(i);
      @(negedge clk);
      if (line_active || line_out || !low_power || !jabber) noisy++;
    end
    chk(noisy == 0, "R8 silent during lockout", noisy, 0);
    tx_en = 1'b0;
    repeat (150) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    tx_en = 1'b0;
    early = 0;
    for (int i = 0; i < UJ - 1; i++) begin @(negedge clk); if (!jabber || line_active) early++; end
    chk(early == 0, "R9 holdoff restarted by glitch", early, 0);
    @(negedge clk);
    chk(jabber === 1'b0, "R9 exit after holdoff", int'(jabber), 0);
  endtask

  task automatic t_resume;
    logic [3:0] a [16];
    for (int i = 0; i < 16; i++) a[i] = 4'(15 - i);
    a[0] = 4'h6; a[1] = 4'h9;
    send_frame(a, 2, "R11 data after lockout");
    chk(jabber === 1'b0, "R11 jabber stays low", int'(jabber), 0);
  endtask

  initial begin
    t_reset;
    t_link("after reset");
    t_data;
    t_link("after data");
    t_jabber;
    t_resume;
    t_link("after lockout");
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule